// File: doc/BRIEF.md
# Windowed LBIST Signature Checker

This block drives a logic self-test run made of a fixed number of trials. In each trial a linear feedback pattern generator feeds a set of scan chains for a fixed number of shift cycles. A stub circuit under test stands in for the logic. A multiple-input signature register compacts the chain responses. The trial sequence is split into four windows of growing size. The controller asks for a golden signature at two kinds of trial. The first kind is each of the first few trials of every window. The second kind is the last trial of every window, where the signature is cumulative. The controller stalls until the golden value arrives over a valid/ready handshake.

A mismatch on one of the first trials of a window puts that trial index into a failure log FIFO. A mismatch on a window's last trial only marks the window. In both cases the signature register is reloaded with the golden value, so later trials compare clean. When the run ends, `done` rises together with a four-bit mask of failing windows. The log is then drained entry by entry for a later fault-isolation pass.

The default parameters shrink the run to 48 trials for simulation. The windows end at trials 5, 12, 24 and 48, and the first 3 trials of each window are compared. The full-scale setting has 100,000 trials, window ends at 100, 1,000, 10,000 and 100,000, and 100 compared trials per window.

Top module: `lbist_win_checker`

## Requirements
- R1: After reset, `busy`, `done`, `gold_req`, `log_valid` and `log_ovf` are 0 and `win_fail` is 0.
- R2: A `start` pulse while idle loads the pattern generator from `prpg_seed` and the signature register from `misr_seed`, then runs trials 1..WIN_END3. Each trial lasts SHIFT_LEN shift cycles. On every shift cycle:
  - the chain stimulus is `s = prpg[NUM_CHAINS-1:0]`;
  - the response is `r[i] = s[i] ^ (s[i+1] & s[i+2])`, with indices taken modulo NUM_CHAINS, XOR `cut_fault[i]`;
  - the signature advances as `misr = {misr[14:0],0} ^ (misr[15] ? 16'h1021 : 0) ^ r`;
  - the pattern generator advances as `prpg = {prpg[14:0], ^(prpg & 16'hD008)}`.
  After the last trial, `busy` falls and `done` rises.
- R3: A golden signature is requested with `gold_req`=1 and `gold_idx` set to the trial index. This happens exactly for the first COMPARE_N trials of every window and for the last trial of every window. With the defaults that is 16 requests: trials 1,2,3,5,6,7,8,12,13,14,15,24,25,26,27,48.
- R4: While `gold_req` is 1 and `gold_vld` is 0, the controller holds, with `gold_req` staying 1 and `gold_idx` unchanged. The transfer happens in a cycle where both are 1.
- R5: When a compared trial among the first COMPARE_N of a window mismatches its golden value, its index is pushed into the failure log and that window's `win_fail` bit is set.
- R6: A failure on a trial outside the first COMPARE_N of a window is flagged only through that window's `win_fail` bit, at the cumulative compare on the window's last trial. No log entry is made for it.
- R7: After any mismatch, the signature register takes the golden value. Only trials whose own responses were corrupted are then reported.
- R8: The log returns indices oldest first. `log_idx` is valid while `log_valid` is 1, and a 1 on `log_pop` removes the head. A failure that arrives while LOG_DEPTH entries are held is dropped and sets the sticky `log_ovf`.
- R9: `start` is ignored while `busy`. An accepted `start` clears `done`, `win_fail`, the log and `log_ovf`.
- R10: `win_fail[k]` is 1 when window k had any failure. Bit 0 is the first window and bit 3 the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run when idle |
| prpg_seed | input | PRPG_W | Pattern generator seed |
| misr_seed | input | SIG_W | Signature register seed |
| cut_fault | input | NUM_CHAINS | Per-chain response flip into the stub circuit |
| cur_trial | output | TRIAL_W | Index of the trial in progress |
| gold_req | output | 1 | Golden value wanted (ready side of the handshake) |
| gold_idx | output | TRIAL_W | Trial whose golden value is wanted |
| gold_vld | input | 1 | Golden value present |
| gold_sig | input | SIG_W | Golden signature |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| win_fail | output | 4 | Failing window mask |
| log_valid | output | 1 | Log head present |
| log_idx | output | TRIAL_W | Log head trial index |
| log_pop | input | 1 | Remove log head |
| log_ovf | output | 1 | Sticky log overflow |

## Verification
The assertions check four rules on every cycle:
- the controller holds while a golden value is outstanding;
- no request is made while idle, and `done` excludes `busy`;
- the failing-window mask only grows during a run;
- the overflow flag stays set until an accepted start clears it, and a start during a run is ignored.

Only the bench scenarios can show the rest. These are the set of trials that get compared, which faults are logged and which are only flagged per window, the restoration of the signature after a mismatch, and the log's ordering and overflow. The bench shows them by injecting response flips into chosen trials and comparing against golden signatures that it computes from the stated formulas.

// File: rtl/lbist_win_pkg.sv
package lbist_win_pkg;
    localparam int NUM_WIN = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_EVAL,
        ST_WAIT
    } ctl_state_e;
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int          W     = 16,
    parameter logic [W-1:0] TAPS = 16'hD008,
    parameter int          OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     seed,
    input  logic             shift_en,
    output logic [OUT_W-1:0] stim
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (load) begin
            lfsr_d = seed;
        end else if (shift_en) begin
            lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= '0;
        else        lfsr_q <= lfsr_d;
    end

    assign stim = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/lbist_cut_stub.sv
module lbist_cut_stub #(
    parameter int N = 4
) (
    input  logic [N-1:0] stim,
    input  logic [N-1:0] fault,
    output logic [N-1:0] resp
);
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign resp[i] = stim[i] ^ (stim[(i+1)%N] & stim[(i+2)%N]) ^ fault[i];
    end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'h1021,
    parameter int           IN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    load_val,
    input  logic            shift_en,
    input  logic [IN_W-1:0] resp,
    output logic [W-1:0]    sig
);
    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (load) begin
            sig_d = load_val;
        end else if (shift_en) begin
            sig_d = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? TAPS : '0)
                    ^ {{(W-IN_W){1'b0}}, resp};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig = sig_q;
endmodule

// File: rtl/lbist_fail_log.sv
module lbist_fail_log #(
    parameter int DEPTH = 4,
    parameter int DW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] head,
    output logic          ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         wr;
        logic [PTR_W-1:0]         rd;
        logic [CNT_W-1:0]         cnt;
        logic                     ovf;
    } log_t;

    log_t s_d, s_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic full, do_push, do_pop;
        s_d     = s_q;
        full    = (s_q.cnt == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (s_q.cnt != '0);
        if (clear) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end else begin
            if (push && full) s_d.ovf = 1'b1;
            if (do_push) begin
                s_d.mem[s_q.wr] = push_data;
                s_d.wr          = bump(s_q.wr);
            end
            if (do_pop) s_d.rd = bump(s_q.rd);
            if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
            else if (do_pop && !do_push) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = (s_q.cnt != '0);
    assign head  = s_q.mem[s_q.rd];
    assign ovf   = s_q.ovf;
endmodule

// File: rtl/lbist_win_checker.sv
module lbist_win_checker
    import lbist_win_pkg::*;
#(
    parameter int                NUM_CHAINS = 4,
    parameter int                PRPG_W     = 16,
    parameter logic [PRPG_W-1:0] PRPG_TAPS  = 16'hD008,
    parameter int                SIG_W      = 16,
    parameter logic [SIG_W-1:0]  MISR_TAPS  = 16'h1021,
    parameter int                SHIFT_LEN  = 4,
    parameter int                WIN_END0   = 5,
    parameter int                WIN_END1   = 12,
    parameter int                WIN_END2   = 24,
    parameter int                WIN_END3   = 48,
    parameter int                COMPARE_N  = 3,
    parameter int                LOG_DEPTH  = 4,
    localparam int               TRIAL_W    = $clog2(WIN_END3 + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [PRPG_W-1:0]     prpg_seed,
    input  logic [SIG_W-1:0]      misr_seed,
    input  logic [NUM_CHAINS-1:0] cut_fault,
    output logic [TRIAL_W-1:0]    cur_trial,
    output logic                  gold_req,
    output logic [TRIAL_W-1:0]    gold_idx,
    input  logic                  gold_vld,
    input  logic [SIG_W-1:0]      gold_sig,
    output logic                  busy,
    output logic                  done,
    output logic [NUM_WIN-1:0]    win_fail,
    output logic                  log_valid,
    output logic [TRIAL_W-1:0]    log_idx,
    input  logic                  log_pop,
    output logic                  log_ovf
);
    localparam int CNT_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1;
    localparam int unsigned ENDS [NUM_WIN] = '{WIN_END0, WIN_END1, WIN_END2, WIN_END3};

    typedef struct packed {
        ctl_state_e         state;
        logic [TRIAL_W-1:0] trial;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic [NUM_WIN-1:0] win_fail;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                  prpg_load, misr_load, shift_en, log_push, log_clear;
    logic [SIG_W-1:0]      misr_val, sig;
    logic [NUM_CHAINS-1:0] stim, resp;
    logic [1:0]            win_idx;
    logic                  in_head, is_last;

    lbist_prpg #(.W(PRPG_W), .TAPS(PRPG_TAPS), .OUT_W(NUM_CHAINS)) u_prpg (
        .clk(clk), .rst_n(rst_n), .load(prpg_load), .seed(prpg_seed),
        .shift_en(shift_en), .stim(stim)
    );

    lbist_cut_stub #(.N(NUM_CHAINS)) u_cut (
        .stim(stim), .fault(cut_fault), .resp(resp)
    );

    lbist_misr #(.W(SIG_W), .TAPS(MISR_TAPS), .IN_W(NUM_CHAINS)) u_misr (
        .clk(clk), .rst_n(rst_n), .load(misr_load), .load_val(misr_val),
        .shift_en(shift_en), .resp(resp), .sig(sig)
    );

    lbist_fail_log #(.DEPTH(LOG_DEPTH), .DW(TRIAL_W)) u_log (
        .clk(clk), .rst_n(rst_n), .clear(log_clear), .push(log_push),
        .push_data(c_q.trial), .pop(log_pop), .valid(log_valid),
        .head(log_idx), .ovf(log_ovf)
    );

    // Window decode: which window holds the current trial, and where in it.
    always_comb begin
        int unsigned lo;
        int unsigned t;
        logic        found;
        lo      = 1;
        t       = int'(c_q.trial);
        found   = 1'b0;
        win_idx = 2'd0;
        in_head = 1'b0;
        is_last = 1'b0;
        for (int k = 0; k < NUM_WIN; k++) begin
            if (!found && t <= ENDS[k]) begin
                found   = 1'b1;
                win_idx = 2'(k);
                in_head = (t - lo) < COMPARE_N;
                is_last = (t == ENDS[k]);
            end
            lo = ENDS[k] + 1;
        end
    end

    always_comb begin
        logic advance;
        c_d       = c_q;
        prpg_load = 1'b0;
        misr_load = 1'b0;
        misr_val  = gold_sig;
        shift_en  = 1'b0;
        log_push  = 1'b0;
        log_clear = 1'b0;
        gold_req  = 1'b0;
        advance   = 1'b0;

        case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    prpg_load    = 1'b1;
                    misr_load    = 1'b1;
                    misr_val     = misr_seed;
                    log_clear    = 1'b1;
                    c_d.done     = 1'b0;
                    c_d.win_fail = '0;
                    c_d.trial    = TRIAL_W'(1);
                    c_d.cnt      = '0;
                    c_d.state    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                shift_en = 1'b1;
                if (c_q.cnt == CNT_W'(SHIFT_LEN - 1)) begin
                    c_d.cnt   = '0;
                    c_d.state = ST_EVAL;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_EVAL: begin
                if (in_head || is_last) c_d.state = ST_WAIT;
                else                    advance   = 1'b1;
            end
            ST_WAIT: begin
                gold_req = 1'b1;
                if (gold_vld) begin
                    if (gold_sig != sig) begin
                        misr_load             = 1'b1;
                        c_d.win_fail[win_idx] = 1'b1;
                        log_push              = in_head;
                    end
                    advance = 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase

        if (advance) begin
            if (c_q.trial == TRIAL_W'(WIN_END3)) begin
                c_d.state = ST_IDLE;
                c_d.done  = 1'b1;
            end else begin
                c_d.trial = c_q.trial + 1'b1;
                c_d.state = ST_SHIFT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign cur_trial = c_q.trial;
    assign gold_idx  = c_q.trial;
    assign busy      = (c_q.state != ST_IDLE);
    assign done      = c_q.done;
    assign win_fail  = c_q.win_fail;
endmodule

// File: rtl/lbist_win_checker_sva.sv
module lbist_win_checker_sva #(
    parameter int TRIAL_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               gold_req,
    input logic               gold_vld,
    input logic [TRIAL_W-1:0] gold_idx,
    input logic [3:0]         win_fail,
    input logic               log_ovf
);
    assert_gold_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gold_req && !gold_vld) |=> (gold_req && $stable(gold_idx)));

    assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gold_req |-> busy);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_win_grow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((win_fail & $past(win_fail)) == $past(win_fail)));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (log_ovf && !(start && !busy)) |=> log_ovf);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !done);
endmodule

bind lbist_win_checker lbist_win_checker_sva #(.TRIAL_W(TRIAL_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .gold_req(gold_req), .gold_vld(gold_vld), .gold_idx(gold_idx),
    .win_fail(win_fail), .log_ovf(log_ovf)
);

// File: tb/test_lbist_win_checker.sv
module test_lbist_win_checker;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   prpg_seed = '0, misr_seed = '0;
    logic [3:0]    cut_fault;
    logic [TW-1:0] cur_trial, gold_idx, log_idx;
    logic          gold_req, gold_vld = 1'b0;
    logic [15:0]   gold_sig = '0;
    logic          busy, done, log_valid, log_ovf;
    logic          log_pop = 1'b0;
    logic [3:0]    win_fail;

    always #4 clk = ~clk;

    lbist_win_checker i_lbist_win_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .prpg_seed(prpg_seed),
        .misr_seed(misr_seed), .cut_fault(cut_fault), .cur_trial(cur_trial),
        .gold_req(gold_req), .gold_idx(gold_idx), .gold_vld(gold_vld),
        .gold_sig(gold_sig), .busy(busy), .done(done), .win_fail(win_fail),
        .log_valid(log_valid), .log_idx(log_idx), .log_pop(log_pop),
        .log_ovf(log_ovf)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    logic [63:0] fault_cur = '0;
    assign cut_fault = (busy && fault_cur[cur_trial]) ? 4'b0001 : 4'b0000;

    logic [15:0] gold_tab [64];
    int          resp_delay = 0, wait_cnt = 0, req_cnt = 0;
    logic [63:0] req_seen = '0;

    typedef struct packed {
        logic [15:0] pseed;
        logic [15:0] mseed;
        logic [63:0] faults;
        logic [1:0]  delay;
        logic [3:0]  mask;
        logic [2:0]  nlog;
        logic        ovf;
        logic [31:0] logs;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{16'hACE1, 16'h0000, 64'h0,                   2'd0, 4'h0, 3'd0, 1'b0, 32'h0},
        '{16'h1234, 16'h5A5A, 64'h4,                   2'd1, 4'h1, 3'd1, 1'b0, 32'h02},
        '{16'h0F0F, 16'hFFFF, 64'h400,                 2'd2, 4'h2, 3'd0, 1'b0, 32'h0},
        '{16'h8001, 16'h1357, 64'h0001_0000_0010_0080, 2'd0, 4'hE, 3'd1, 1'b0, 32'h07},
        '{16'hBEEF, 16'h0042, 64'h0000_0000_0C00_404A, 2'd3, 4'hF, 3'd4, 1'b1, 32'h0E060301},
        '{16'h7777, 16'hC001, 64'h70,                  2'd1, 4'h3, 3'd1, 1'b0, 32'h06},
        '{16'h4D2B, 16'h9999, 64'h4200_0000,           2'd2, 4'h8, 3'd1, 1'b0, 32'h19}
    };

    localparam logic [63:0] EXP_REQ = 64'h0001_0000_0F00_F1EE;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] prpg_step(input logic [15:0] p);
        return {p[14:0], p[15] ^ p[14] ^ p[12] ^ p[3]};
    endfunction

    function automatic logic [15:0] misr_step(input logic [15:0] m, input logic [3:0] r);
        logic [15:0] n;
        n = {m[14:0], 1'b0};
        if (m[15]) n = n ^ 16'h1021;
        return n ^ {12'b0, r};
    endfunction

    function automatic logic [3:0] cut_resp(input logic [3:0] s);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = s[i] ^ (s[(i+1)%4] & s[(i+2)%4]);
        return r;
    endfunction

    task automatic build_gold(input logic [15:0] ps, input logic [15:0] ms);
        logic [15:0] p, m;
        p = ps;
        m = ms;
        for (int t = 0; t < 64; t++) gold_tab[t] = '0;
        for (int t = 1; t <= 48; t++) begin
            for (int c = 0; c < 4; c++) begin
                m = misr_step(m, cut_resp(p[3:0]));
                p = prpg_step(p);
            end
            gold_tab[t] = m;
        end
    endtask

    // Golden responder: answers each request after resp_delay idle cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (gold_vld) begin
                gold_vld = 1'b0;
            end else if (gold_req) begin
                if (wait_cnt >= resp_delay) begin
                    gold_vld = 1'b1;
                    gold_sig = gold_tab[gold_idx];
                    req_seen[gold_idx] = 1'b1;
                    req_cnt++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic run_vec(input vec_t v, input int id, input bit poke_start);
        bit ok;
        int n;
        build_gold(v.pseed, v.mseed);
        fault_cur  = v.faults;
        resp_delay = int'(v.delay);
        req_cnt    = 0;
        req_seen   = '0;
        @(negedge clk);
        prpg_seed = v.pseed;
        misr_seed = v.mseed;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: accepted start clears the previous run's results
        chk(busy && !done && win_fail == 0 && !log_valid && !log_ovf,
            $sformatf("R9 clear on start vec%0d", id),
            {busy, done, win_fail, log_valid, log_ovf}, 8'h80);
        if (poke_start) begin
            repeat (10) @(negedge clk);
            prpg_seed = ~v.pseed;
            misr_seed = ~v.mseed;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk(ok && !busy, $sformatf("R2 done vec%0d", id), {ok, busy}, 2'b10);
        chk(win_fail == v.mask, $sformatf("R5 R6 R7 R10 mask vec%0d", id), win_fail, v.mask);
        chk(req_cnt == 16 && req_seen == EXP_REQ, $sformatf("R3 requests vec%0d", id),
            req_seen, EXP_REQ);
        chk(log_ovf == v.ovf, $sformatf("R8 overflow vec%0d", id), log_ovf, v.ovf);
        n = 0;
        while (log_valid && n < 8) begin
            if (n < 4)
                chk(log_idx == TW'(v.logs[n*8 +: 8]), $sformatf("R5 R8 log%0d vec%0d", n, id),
                    log_idx, v.logs[n*8 +: 8]);
            n++;
            log_pop = 1'b1;
            @(negedge clk);
            log_pop = 1'b0;
        end
        chk(n == int'(v.nlog), $sformatf("R6 R8 log count vec%0d", id), n, v.nlog);
        fault_cur = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !gold_req && !log_valid && !log_ovf && win_fail == 0,
            "R1 reset state", {busy, done, gold_req, log_valid, log_ovf, win_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !gold_req, "R1 idle after reset", {busy, done, gold_req}, 0);
        for (int k = 0; k < 7; k++) run_vec(VEC[k], k, 1'b0);
        // R9: start pulse in mid-run must not restart with new seeds
        run_vec(VEC[0], 7, 1'b1);
        // R8: after overflow run, a fresh start clears the flag
        run_vec(VEC[4], 8, 1'b0);
        run_vec(VEC[2], 9, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule